// File: doc/BRIEF.md
# Nibble Link Boot Receiver

This block loads a boot image into local instruction memory over a narrow link. An external device drives a link clock and a 4-bit data bus. The block shifts in twelve nibbles per word, most significant nibble first, and forms 48-bit instruction words. Each finished word crosses into the core clock domain over a toggle handshake. A small address-and-count engine then writes the word to memory: the first word goes to a start address, and each later word goes to the next address.

The block receives only while a 3-bit boot strap input holds the link-boot code. The sender has no acknowledge or back-pressure, so every nibble that arrives must be taken. The memory write port is a plain write strobe, because the memory always accepts writes.

When the programmed number of words has been written, a completion interrupt is raised. The interrupt stays pending and the receiver stays closed until software pulses the clear input. Only after that clear can a new boot begin.

Top module: `link_boot_rx`

## Requirements
- R1: Twelve 4-bit nibbles form one 48-bit word. The first nibble received becomes bits 47:44, and each later nibble fills the next lower four bits.
- R2: A nibble is captured on the falling edge of the link clock. Data that changes just after the rising edge is taken with its new value.
- R3: Words are received correctly for any link clock period from the core clock period upward.
- R4: The receiver is enabled only when the strap input equals 3'b110 (bit 0 low, bits 1 and 2 high). With any other strap value, no memory write and no interrupt occur.
- R5: Each boot writes its first word at the start address sampled when the boot starts. Each later word goes to the previous address plus one.
- R6: After the programmed word count has been written, the interrupt rises and stays high until the clear input is pulsed.
- R7: While the interrupt is pending, link nibbles are ignored and cause no memory write.
- R8: A new boot begins only after the interrupt is cleared. The new boot reloads the start address and the count, and the interrupt falls on the cycle after the clear.
- R9: A count of zero raises the interrupt without any memory write.
- R10: Synchronous active-high reset clears the interrupt and the write strobe, and discards a partly assembled word.
- R11: Back-to-back words, sent without any flow control, each produce exactly one write. No word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, core domain |
| link_clk | input | 1 | Link clock from the sender; data is taken on its falling edge |
| link_nib | input | 4 | Link data nibble |
| boot_strap | input | 3 | Boot-mode strap pins; 3'b110 selects link boot |
| start_addr | input | 16 | First memory address of a boot |
| word_count | input | 16 | Number of words in a boot |
| irq_clr | input | 1 | Pulse that clears a pending completion interrupt |
| mem_we | output | 1 | Memory write strobe, one core cycle per word |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 48 | Memory write data |
| boot_irq | output | 1 | Completion interrupt, held until cleared |

## Verification
The assertions assume the following about the inputs:
- The straps change only while the engine is idle or done.
- The link clock is never faster than the core clock, so two word strobes never fall on adjacent core cycles.
- The sender is silent while the link-side clear releases, and it starts only after the enable settles.

The bench keeps within these limits. It drives link periods of 20 ns and 74 ns, and it changes the straps only outside a running boot. After every enable or reset, it waits a dozen core cycles before sending the first nibble.

// File: rtl/lbr_pkg.sv
`timescale 1ns/1ps
package lbr_pkg;
  // strap value that opens the link boot path
  localparam logic [2:0] LINK_BOOT_CODE = 3'b110;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dma_st_e;
endpackage

// File: rtl/lbr_nibble_packer.sv
`timescale 1ns/1ps
// Link-clock domain: shifts nibbles in, MSB first, and publishes whole words
module lbr_nibble_packer #(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 48
) (
  input  logic              lclk,
  input  logic              clr,      // asynchronous, held from core domain
  input  logic [NIB_W-1:0]  nib_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_tgl
);
  localparam int NIBS = WORD_W / NIB_W;
  localparam int CW   = $clog2(NIBS);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] shifted;

  assign shifted = {asm_q[WORD_W-NIB_W-1:0], nib_in};

  always_ff @(negedge lclk or posedge clr) begin
    if (clr) begin
      cnt      <= '0;
      asm_q    <= '0;
      word_out <= '0;
      word_tgl <= 1'b0;
    end else if (cnt == CW'(NIBS - 1)) begin
      word_out <= shifted;
      word_tgl <= ~word_tgl;
      cnt      <= '0;
      asm_q    <= '0;
    end else begin
      asm_q <= shifted;
      cnt   <= cnt + CW'(1);
    end
  end

  AST_NIB_CNT_RANGE: assert property (@(negedge lclk) disable iff (clr)
    cnt < CW'(NIBS)) else $error("nibble counter out of range"); // R1

  AST_TGL_ON_LAST: assert property (@(negedge lclk) disable iff (clr)
    (cnt != CW'(NIBS - 1)) |=> $stable(word_tgl)) else $error("early word toggle"); // R1
endmodule

// File: rtl/lbr_word_sync.sv
`timescale 1ns/1ps
// Toggle handshake into the core domain; the link side holds the word
// stable for a full word time, which outlasts the synchronizer delay.
module lbr_word_sync #(
  parameter int WORD_W = 48,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tgl_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_q
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              edge_seen;

  assign edge_seen = sync_q[STAGES-1] ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      word_stb <= 1'b0;
      word_q   <= '0;
    end else begin
      sync_q   <= {sync_q[STAGES-2:0], tgl_in};
      prev_q   <= sync_q[STAGES-1];
      word_stb <= edge_seen;
      if (edge_seen) word_q <= word_in;
    end
  end

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb) else $error("word strobes adjacent"); // R11
endmodule

// File: rtl/lbr_dma_engine.sv
`timescale 1ns/1ps
// Core domain: address/count engine, completion interrupt and link gating
module lbr_dma_engine
  import lbr_pkg::*;
#(
  parameter int WORD_W = 48,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_en,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              irq_clr,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_q,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              irq,
  output logic              link_clr
);
  localparam int SW = $clog2(SETTLE + 1);

  dma_st_e           state;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  remain;
  logic [SW-1:0]     settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr      <= '0;
      remain    <= '0;
      settle    <= '0;
      irq       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      link_clr  <= 1'b1;
    end else begin
      mem_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          link_clr <= 1'b1;
          if (!boot_en) begin
            settle <= '0;
          end else if (settle == SW'(SETTLE - 1)) begin
            settle <= '0;
            addr   <= start_addr;
            remain <= word_count;
            if (word_count == '0) begin
              irq   <= 1'b1;
              state <= ST_DONE;
            end else begin
              link_clr <= 1'b0;
              state    <= ST_RUN;
            end
          end else begin
            settle <= settle + SW'(1);
          end
        end
        ST_RUN: begin
          if (word_stb) begin
            mem_we    <= 1'b1;
            mem_addr  <= addr;
            mem_wdata <= word_q;
            addr      <= addr + ADDR_W'(1);
            remain    <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) begin
              irq      <= 1'b1;
              link_clr <= 1'b1;
              state    <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          link_clr <= 1'b1;
          if (irq_clr) begin
            irq   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(state) == ST_RUN) else $error("write outside run"); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> addr == mem_addr + ADDR_W'(1)) else $error("address not stepped"); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq) else $error("interrupt dropped"); // R6

  AST_IRQ_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> state == ST_DONE) else $error("interrupt outside done"); // R8
endmodule

// File: rtl/link_boot_rx.sv
`timescale 1ns/1ps
module link_boot_rx
  import lbr_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int WORD_W      = 48,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_clk,
  input  logic [NIB_W-1:0]  link_nib,
  input  logic [2:0]        boot_strap,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              irq_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              boot_irq
);
  localparam int SETTLE = SYNC_STAGES + 2;

  logic [2:0]        strap_s1, strap_s2;
  logic              boot_en;
  logic              link_clr;
  logic [WORD_W-1:0] link_word;
  logic              link_tgl;
  logic              word_stb;
  logic [WORD_W-1:0] word_q;

  // strap pins are asynchronous; two flops, then decode
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_s1 <= '0;
      strap_s2 <= '0;
      boot_en  <= 1'b0;
    end else begin
      strap_s1 <= boot_strap;
      strap_s2 <= strap_s1;
      boot_en  <= (strap_s2 == LINK_BOOT_CODE);
    end
  end

  lbr_nibble_packer #(.NIB_W(NIB_W), .WORD_W(WORD_W)) u_packer (
    .lclk     (link_clk),
    .clr      (link_clr),
    .nib_in   (link_nib),
    .word_out (link_word),
    .word_tgl (link_tgl)
  );

  lbr_word_sync #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .tgl_in   (link_tgl),
    .word_in  (link_word),
    .word_stb (word_stb),
    .word_q   (word_q)
  );

  lbr_dma_engine #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETTLE(SETTLE)
  ) u_dma (
    .clk        (clk),
    .rst        (rst),
    .boot_en    (boot_en),
    .start_addr (start_addr),
    .word_count (word_count),
    .irq_clr    (irq_clr),
    .word_stb   (word_stb),
    .word_q     (word_q),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .irq        (boot_irq),
    .link_clr   (link_clr)
  );

  AST_STRAP_GATE: assert property (@(posedge clk) disable iff (rst)
    (!boot_en && $past(!boot_en) && !boot_irq) |-> !mem_we) else $error("write with strap off"); // R4
endmodule

// File: tb/link_boot_rx_test.sv
`timescale 1ns/1ps
module link_boot_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_clk = 1'b0;
  logic [3:0]  link_nib = '0;
  logic [2:0]  boot_strap = 3'b110;
  logic [15:0] start_addr = 16'h0100;
  logic [15:0] word_count = 16'd3;
  logic        irq_clr = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [47:0] mem_wdata;
  logic        boot_irq;

  always #10 clk = ~clk;   // 50 MHz

  link_boot_rx uut (
    .clk(clk), .rst(rst), .link_clk(link_clk), .link_nib(link_nib),
    .boot_strap(boot_strap), .start_addr(start_addr), .word_count(word_count),
    .irq_clr(irq_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .boot_irq(boot_irq)
  );

  int errors = 0;
  int checks = 0;
  int writes = 0;
  bit ended  = 0;
  logic [63:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] pat(input int i);
    return 48'h1234_5678_9ABC ^ (48'(i) * 48'h1111_0F0F_3C3C);
  endfunction

  // data changes just after the rising edge; capture must be on the fall (R2)
  task automatic send_nib(input logic [3:0] n, input int half);
    link_clk = 1'b1;
    #1 link_nib = n;
    #(half - 1) link_clk = 1'b0;
    #(half);
  endtask

  task automatic send_word(input logic [47:0] w, input int half,
                           input bit expect_wr, input logic [15:0] a);
    if (expect_wr) exp_q.push_back({a, w});
    for (int i = 0; i < 12; i++) send_nib(w[47 - 4*i -: 4], half);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      writes++;
      if (exp_q.size() == 0)
        chk(1'b0, "R7", "unexpected write", {mem_addr, mem_wdata}, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R1/R5", "write addr+data",
            {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    wait_cyc(5);
    chk(boot_irq == 1'b0, "R10", "irq in reset", 64'(boot_irq), 64'h0);
    chk(mem_we == 1'b0, "R10", "we in reset", 64'(mem_we), 64'h0);
    @(negedge clk) rst = 1'b0;
    wait_cyc(12);

    // fast link clock equal to core clock
    for (int i = 0; i < 3; i++) send_word(pat(i), 10, 1'b1, 16'h0100 + 16'(i));
    wait_cyc(10);
    chk(boot_irq == 1'b1, "R6", "irq after count", 64'(boot_irq), 64'h1);
    chk(writes == 3, "R11", "write count", 64'(writes), 64'd3);

    // nibbles while pending are ignored
    send_word(pat(9), 10, 1'b0, 16'h0);
    wait_cyc(10);
    chk(writes == 3, "R7", "writes while pending", 64'(writes), 64'd3);

    // new parameters take no effect until cleared
    start_addr = 16'h0200; word_count = 16'd2;
    wait_cyc(40);
    chk(boot_irq == 1'b1, "R6", "irq held", 64'(boot_irq), 64'h1);
    pulse_clear();
    chk(boot_irq == 1'b0, "R8", "irq after clear", 64'(boot_irq), 64'h0);
    wait_cyc(12);
    // slow link clock
    send_word(pat(20), 37, 1'b1, 16'h0200);
    send_word(pat(21), 37, 1'b1, 16'h0201);
    wait_cyc(10);
    chk(boot_irq == 1'b1, "R3", "irq slow boot", 64'(boot_irq), 64'h1);
    chk(writes == 5, "R8", "restart writes", 64'(writes), 64'd5);

    // strap decode
    boot_strap = 3'b000;
    wait_cyc(4);
    pulse_clear();
    for (int c = 0; c < 8; c++) begin
      if (c != 6) begin
        boot_strap = 3'(c);
        wait_cyc(12);
        send_word(pat(30 + c), 10, 1'b0, 16'h0);
        wait_cyc(10);
      end
    end
    chk(writes == 5, "R4", "writes with strap off", 64'(writes), 64'd5);
    chk(boot_irq == 1'b0, "R4", "irq with strap off", 64'(boot_irq), 64'h0);

    // zero count
    word_count = 16'd0;
    boot_strap = 3'b110;
    wait_cyc(15);
    chk(boot_irq == 1'b1, "R9", "irq on zero count", 64'(boot_irq), 64'h1);
    chk(writes == 5, "R9", "writes on zero count", 64'(writes), 64'd5);

    // partial word discarded by reset
    start_addr = 16'h0300; word_count = 16'd2;
    pulse_clear();
    wait_cyc(12);
    for (int i = 0; i < 5; i++) send_nib(4'hF, 10);
    @(negedge clk) rst = 1'b1;
    wait_cyc(3);
    chk(boot_irq == 1'b0, "R10", "irq during reset", 64'(boot_irq), 64'h0);
    @(negedge clk) rst = 1'b0;
    wait_cyc(12);
    send_word(pat(40), 10, 1'b1, 16'h0300);
    send_word(pat(41), 10, 1'b1, 16'h0301);
    wait_cyc(10);
    chk(writes == 7, "R10", "writes after reset", 64'(writes), 64'd7);
    chk(boot_irq == 1'b1, "R6", "irq after reset boot", 64'(boot_irq), 64'h1);
    chk(exp_q.size() == 0, "R11", "words left unwritten", 64'(exp_q.size()), 64'h0);

    finish_run();
  end
endmodule